// File: doc/BRIEF.md
# Dual-Channel UART Register Front End with Broadcast Write

This block sits between one CPU register bus and two identical UART channels. A channel-select input steers each bus access to one channel. The block forwards write strobes, the register offset and the write data to the channels, and it returns read data from the chosen channel. Each channel supplies its own divisor-latch-access bit (bit 7 of its line-control register). The block uses that bit to decide how the channel interprets an access.

The block also holds a small shared alternate-function register. Bit 0 of that register enables broadcast. While broadcast is on, every CPU write reaches the same offset in both channels in the same cycle, which halves the time needed to bring both channels up in the same state. Reads still come from the selected channel only. Bits 2:1 of the register select what the multifunction output pin carries, and the block drives that selection out for the pin logic. The register sits at offset `AFR_OFFSET`. A channel sees it in place of its own register at that offset whenever that channel's divisor-latch-access bit is 1. Bits 2:0 are the only stored bits.

Top module: `uart_pair_regfront`

## Requirements
- R1: After reset the alternate-function register is 0. `bcast_on` is 0, `mf_sel` is 00, and reading the register through either channel returns 0.
- R2: With `bcast_on` at 0, a CPU write raises the write strobe of the selected channel only. `ch_wr[0]` belongs to `cpu_sel`=0 and `ch_wr[1]` to `cpu_sel`=1, and the other strobe stays 0.
- R3: With `bcast_on` at 1, a CPU write raises both `ch_wr` bits in the same cycle. The exception is a channel that decodes the access as the alternate-function register (see R8). `ch_addr` and `ch_wdata` equal `cpu_addr` and `cpu_wdata` in the same cycle.
- R4: The register is one shared copy. It is written when `cpu_wr` is 1, `cpu_addr` equals `AFR_OFFSET`, and the `lcr7_in` bit of a channel targeted by the write is 1. This works through either channel's select value. The register keeps its value on all other cycles.
- R5: With `cpu_rd` at 1, and outside the case in R6, `cpu_rdata` equals the selected channel's slice of `ch_rdata`. Channel 0 uses bits 7:0 and channel 1 uses bits 15:8. `bcast_on` has no effect on which channel is read.
- R6: When `cpu_rd` is 1, `cpu_addr` equals `AFR_OFFSET` and `lcr7_in[cpu_sel]` is 1, `cpu_rdata` is {5'b0, mf_sel, bcast_on}. The value is the same from either channel, and bits 7:3 read as 0 even after 1s are written to them.
- R7: `mf_sel` equals stored bits 2:1 and `bcast_on` equals stored bit 0. Both take the written `cpu_wdata[2:0]` on the clock edge that ends the write cycle, and show it from the next cycle on.
- R8: Each written channel decodes with its own `lcr7_in` bit. At offsets 0 and 1, `ch_dl[i]` is 1 exactly when `ch_wr[i]` is 1 and `lcr7_in[i]` is 1. At `AFR_OFFSET`, a channel whose `lcr7_in` bit is 1 gets no `ch_wr` strobe, and a channel whose bit is 0 gets its normal strobe.
- R9: While `cpu_rd` is 0, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | CPU write cycle |
| cpu_rd | input | 1 | CPU read cycle |
| cpu_sel | input | 1 | Channel select, 0 or 1 |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| lcr7_in | input | 2 | Divisor-latch-access bit of each channel |
| ch_rdata | input | 16 | Read data of channel 1 (15:8) and channel 0 (7:0) |
| ch_wr | output | 2 | Per-channel write strobe |
| ch_dl | output | 2 | Per-channel divisor-latch bank flag for the current write |
| ch_addr | output | 3 | Offset forwarded to the channels |
| ch_wdata | output | 8 | Write data forwarded to the channels |
| mf_sel | output | 2 | Multifunction-output selector |
| bcast_on | output | 1 | Broadcast enable |

## Verification
Directed steps turn broadcast on through channel 1 and read the register back through channel 0, and then clear it through channel 0. This shows that both select values reach one shared copy. Broadcast writes at offsets 0, 1 and the alternate-function offset are made with the two `lcr7_in` bits set differently. These writes separate a per-channel decode from one that uses the selected channel's bit for both channels. The random phase draws the select, the offset (biased toward the alternate-function slot), the write data, both `lcr7_in` bits and both channels' read data. Reads in that phase catch any path in which the broadcast state leaks into the read mux or the stored bits 7:3 leak into the read data.

// File: rtl/uart_pair_pkg.sv
package uart_pair_pkg;

  localparam int NCH = 2;
  localparam int AFR_BITS = 3;

  typedef struct packed {
    logic [1:0] mf;
    logic       bcast;
  } afr_t;

  function automatic afr_t afr_from_word(input logic [AFR_BITS-1:0] w);
    afr_t r;
    r.mf    = w[2:1];
    r.bcast = w[0];
    return r;
  endfunction

  function automatic logic [AFR_BITS-1:0] afr_to_bits(input afr_t a);
    return {a.mf, a.bcast};
  endfunction

endpackage

// File: rtl/uart_pair_chan_dec.sv
module uart_pair_chan_dec #(
  parameter int AW       = 3,
  parameter int SEL_W    = 1,
  parameter int IDX      = 0,
  parameter int AFR_OFF  = 2,
  parameter int DL_LAST  = 1
) (
  input  logic             cpu_wr,
  input  logic [SEL_W-1:0] cpu_sel,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             bcast,
  input  logic             dlab,
  output logic             wr_o,
  output logic             dl_o,
  output logic             afr_wr_o,
  output logic             afr_slot_o
);

  logic targeted;
  logic in_dl_range;

  function automatic logic slot_is_afr(input logic [AW-1:0] a, input logic d);
    return (a == AW'(AFR_OFF)) && d;
  endfunction

  always_comb begin
    targeted    = bcast || (int'(cpu_sel) == IDX);
    in_dl_range = (int'(cpu_addr) <= DL_LAST);
    afr_slot_o  = slot_is_afr(cpu_addr, dlab);
    wr_o        = cpu_wr && targeted && !afr_slot_o;
    dl_o        = wr_o && dlab && in_dl_range;
    afr_wr_o    = cpu_wr && targeted && afr_slot_o;
  end

endmodule

// File: rtl/uart_pair_afr.sv
module uart_pair_afr
  import uart_pair_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output afr_t          afr_q,
  output logic [DW-1:0] rd_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      afr_q <= '0;
    end else if (we) begin
      afr_q <= afr_from_word(wdata[AFR_BITS-1:0]);
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[AFR_BITS-1:0] = afr_to_bits(afr_q);
  end

endmodule

// File: rtl/uart_pair_rdmux.sv
module uart_pair_rdmux #(
  parameter int DW    = 8,
  parameter int NCH   = 2,
  parameter int SEL_W = 1
) (
  input  logic              cpu_rd,
  input  logic [SEL_W-1:0]  cpu_sel,
  input  logic [NCH*DW-1:0] ch_rdata,
  input  logic [NCH-1:0]    afr_slot,
  input  logic [DW-1:0]     afr_word,
  output logic [DW-1:0]     rdata
);

  logic [DW-1:0] lane [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane[g] = ch_rdata[g*DW +: DW];
  end

  always_comb begin
    rdata = '0;
    if (cpu_rd) begin
      if (afr_slot[cpu_sel]) rdata = afr_word;
      else                   rdata = lane[cpu_sel];
    end
  end

endmodule

// File: rtl/uart_pair_regfront.sv
module uart_pair_regfront
  import uart_pair_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int AFR_OFFSET = 2,
  parameter int DL_TOP     = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_wr,
  input  logic                  cpu_rd,
  input  logic                  cpu_sel,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [DATA_W-1:0]     cpu_wdata,
  output logic [DATA_W-1:0]     cpu_rdata,
  input  logic [1:0]            lcr7_in,
  input  logic [2*DATA_W-1:0]   ch_rdata,
  output logic [1:0]            ch_wr,
  output logic [1:0]            ch_dl,
  output logic [ADDR_W-1:0]     ch_addr,
  output logic [DATA_W-1:0]     ch_wdata,
  output logic [1:0]            mf_sel,
  output logic                  bcast_on
);

  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  afr_t             afr_q;
  logic [DATA_W-1:0] afr_word;
  logic [NCH-1:0]   afr_wr_lane;
  logic [NCH-1:0]   afr_slot;
  logic             afr_we;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    uart_pair_chan_dec #(
      .AW      (ADDR_W),
      .SEL_W   (SEL_W),
      .IDX     (i),
      .AFR_OFF (AFR_OFFSET),
      .DL_LAST (DL_TOP)
    ) u_dec (
      .cpu_wr     (cpu_wr),
      .cpu_sel    (cpu_sel),
      .cpu_addr   (cpu_addr),
      .bcast      (afr_q.bcast),
      .dlab       (lcr7_in[i]),
      .wr_o       (ch_wr[i]),
      .dl_o       (ch_dl[i]),
      .afr_wr_o   (afr_wr_lane[i]),
      .afr_slot_o (afr_slot[i])
    );
  end

  assign afr_we = |afr_wr_lane;

  uart_pair_afr #(.DW(DATA_W)) u_afr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (afr_we),
    .wdata   (cpu_wdata),
    .afr_q   (afr_q),
    .rd_word (afr_word)
  );

  uart_pair_rdmux #(.DW(DATA_W), .NCH(NCH), .SEL_W(SEL_W)) u_rdmux (
    .cpu_rd   (cpu_rd),
    .cpu_sel  (cpu_sel),
    .ch_rdata (ch_rdata),
    .afr_slot (afr_slot),
    .afr_word (afr_word),
    .rdata    (cpu_rdata)
  );

  assign ch_addr  = cpu_addr;
  assign ch_wdata = cpu_wdata;
  assign mf_sel   = afr_q.mf;
  assign bcast_on = afr_q.bcast;

endmodule

// File: rtl/uart_pair_regfront_chk.sv
module uart_pair_regfront_chk #(
  parameter int AW      = 3,
  parameter int DW      = 8,
  parameter int AFR_OFF = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic          cpu_sel,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic [1:0]    lcr7_in,
  input logic [1:0]    ch_wr,
  input logic [1:0]    mf_sel,
  input logic          bcast_on,
  input logic          afr_we
);

  // R2: without broadcast the unselected strobe stays low
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bcast_on && cpu_wr) |-> (cpu_sel ? !ch_wr[0] : !ch_wr[1]));

  // R3: broadcast outside the shared slot strobes both channels
  assert_both_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_on && cpu_wr && cpu_addr != AW'(AFR_OFF)) |-> (ch_wr == 2'b11));

  // R4: stored bits move only on a register write
  assert_bits_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !afr_we |=> $stable({mf_sel, bcast_on}));

  // R7: a register write loads the low data bits
  assert_bits_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    afr_we |=> ({mf_sel, bcast_on} == $past(cpu_wdata[2:0])));

  // R6: register readback from either channel
  assert_afr_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == AW'(AFR_OFF) && lcr7_in[cpu_sel])
      |-> (cpu_rdata == DW'({mf_sel, bcast_on})));

  // R8: a channel decoding the shared slot gets no strobe
  assert_no_slot_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == AW'(AFR_OFF)) |-> ((ch_wr & lcr7_in) == 2'b00));

  // R9: idle read bus is zero
  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (cpu_rdata == '0));

endmodule

bind uart_pair_regfront uart_pair_regfront_chk #(
  .AW(ADDR_W), .DW(DATA_W), .AFR_OFF(AFR_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_wr    (cpu_wr),
  .cpu_rd    (cpu_rd),
  .cpu_sel   (cpu_sel),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rdata (cpu_rdata),
  .lcr7_in   (lcr7_in),
  .ch_wr     (ch_wr),
  .mf_sel    (mf_sel),
  .bcast_on  (bcast_on),
  .afr_we    (afr_we)
);

// File: tb/test_uart_pair_regfront.sv
module test_uart_pair_regfront;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        cpu_sel = 1'b0;
  logic [2:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [1:0]  lcr7_in = '0;
  logic [15:0] ch_rdata = '0;
  logic [1:0]  ch_wr;
  logic [1:0]  ch_dl;
  logic [2:0]  ch_addr;
  logic [7:0]  ch_wdata;
  logic [1:0]  mf_sel;
  logic        bcast_on;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [2:0] model = 3'b000;   // {mf[1:0], bcast}

  always #5 clk = ~clk;

  uart_pair_regfront i_uart_pair_regfront (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_sel(cpu_sel), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .lcr7_in(lcr7_in), .ch_rdata(ch_rdata),
    .ch_wr(ch_wr), .ch_dl(ch_dl), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
    .mf_sel(mf_sel), .bcast_on(bcast_on)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_slot(input logic [2:0] a, input logic d);
    return (a == 3'd2) && d;
  endfunction

  function automatic logic reaches(input int ch, input logic s, input logic b);
    return b || (int'(s) == ch);
  endfunction

  function automatic logic [1:0] exp_wr(input logic w, input logic s,
                                        input logic [2:0] a, input logic [1:0] l7,
                                        input logic b);
    logic [1:0] r;
    for (int c = 0; c < 2; c++) r[c] = w && reaches(c, s, b) && !is_slot(a, l7[c]);
    return r;
  endfunction

  function automatic logic [1:0] exp_dl(input logic [1:0] wr, input logic [2:0] a,
                                        input logic [1:0] l7);
    return (a < 3'd2) ? (wr & l7) : 2'b00;
  endfunction

  function automatic logic slot_write(input logic w, input logic s,
                                      input logic [2:0] a, input logic [1:0] l7,
                                      input logic b);
    logic hit = 1'b0;
    for (int c = 0; c < 2; c++) if (reaches(c, s, b) && is_slot(a, l7[c])) hit = 1'b1;
    return w && hit;
  endfunction

  function automatic logic [7:0] exp_rd(input logic r, input logic s, input logic [2:0] a,
                                        input logic [1:0] l7, input logic [15:0] cr,
                                        input logic [2:0] m);
    if (!r) return 8'h00;
    if (is_slot(a, l7[s])) return {5'b0, m};
    return s ? cr[15:8] : cr[7:0];
  endfunction

  // one bus cycle: drive at negedge, check 1 ns later, update model at posedge
  task automatic step(input logic w, input logic r, input logic s, input logic [2:0] a,
                      input logic [7:0] d, input logic [1:0] l7, input logic [15:0] cr);
    logic [1:0] ew;
    @(negedge clk);
    cpu_wr = w; cpu_rd = r; cpu_sel = s; cpu_addr = a;
    cpu_wdata = d; lcr7_in = l7; ch_rdata = cr;
    #1;
    chk("R7 stored bits", {29'b0, mf_sel, bcast_on}, {29'b0, model});
    ew = exp_wr(w, s, a, l7, model[0]);
    chk(model[0] ? "R3 broadcast strobes" : "R2 single strobe", ch_wr, ew);
    chk("R8 per-channel bank", ch_dl, exp_dl(ew, a, l7));
    chk("R3 forwarded offset/data", {ch_addr, ch_wdata}, {a, d});
    chk(!r ? "R9 idle read" : (is_slot(a, l7[s]) ? "R6 register readback" : "R5 channel read"),
        cpu_rdata, exp_rd(r, s, a, l7, cr, model));
    if (slot_write(w, s, a, l7, model[0])) model = d[2:0];
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c2a));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 bcast after reset", bcast_on, 0);
    chk("R1 mf_sel after reset", mf_sel, 0);
    rst_n = 1'b1;
    step(0, 1, 0, 3'd2, 8'h00, 2'b11, 16'hA5C3);   // R1 readback ch0
    step(0, 1, 1, 3'd2, 8'h00, 2'b11, 16'hA5C3);   // R1 readback ch1
    chk("R1 readback zero", cpu_rdata, 0);
    // R2: plain writes to each channel
    step(1, 0, 0, 3'd3, 8'h11, 2'b00, 16'h0);
    step(1, 0, 1, 3'd0, 8'h22, 2'b11, 16'h0);
    // R4: set broadcast and mf through channel 1, upper bits must read 0 (R6)
    step(1, 0, 1, 3'd2, 8'hFF, 2'b10, 16'h0);
    step(0, 1, 0, 3'd2, 8'h00, 2'b01, 16'h1234);
    chk("R6 masked readback", cpu_rdata, 8'h07);
    chk("R7 mf_sel output", mf_sel, 2'b11);
    // R3/R8: broadcast writes with differing latch bits
    step(1, 0, 0, 3'd0, 8'h5A, 2'b01, 16'h0);
    step(1, 0, 1, 3'd1, 8'h6B, 2'b10, 16'h0);
    step(1, 0, 0, 3'd4, 8'h7C, 2'b00, 16'h0);
    step(1, 0, 1, 3'd2, 8'hC7, 2'b00, 16'h0);      // R8 slot with no latch bit: FCR-like strobes
    // R5: reads during broadcast stay single-channel
    step(0, 1, 1, 3'd5, 8'h00, 2'b00, 16'hBEEF);
    step(0, 1, 0, 3'd5, 8'h00, 2'b00, 16'hBEEF);
    // R4: clear through channel 0 while channel 1 decodes normally
    step(1, 0, 0, 3'd2, 8'h02, 2'b01, 16'h0);
    step(1, 0, 0, 3'd6, 8'h33, 2'b11, 16'h0);      // R2 after clear
    chk("R4 cleared via channel 0", bcast_on, 0);
    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a;
      a = ($urandom % 3 == 0) ? 3'd2 : 3'($urandom);
      step(1'($urandom), 1'($urandom), 1'($urandom), a, 8'($urandom),
           2'($urandom), 16'($urandom));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule